// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. A control input turns the operation into a subtraction by inverting the sign of the second operand. The datapath runs in a fixed order:

1. Each operand is unpacked into sign, exponent and significand, and classified.
2. The larger-magnitude operand is placed first.
3. The smaller significand is shifted right to line up with the larger one. Guard, round and sticky bits are kept during the shift.
4. The significands are added or subtracted, depending on the effective operation.
5. The raw sum is normalized, either one place right or left by a leading-zero count.
6. The result is rounded to nearest, ties to even, and packed back into a 32-bit word.

Special operands are handled beside the datapath and override its result where they apply: NaNs, infinities, zeros, and subnormal inputs, which are treated as zero.

The operand and the control bits are taken on an input strobe. The result and two flags, invalid-operation and overflow, are registered and appear one clock later together with an output strobe.

Top module: `fp32_addsub`

## Requirements
- R1: After reset `out_valid` is 0, `result` is 0 and both flags are 0. `out_valid` equals `in_valid` delayed by one clock. `result`, `flag_invalid` and `flag_overflow` belong to the inputs of the previous cycle.
- R2: For normal operands the result is the exact sum rounded to nearest. The smaller operand is aligned right by the exponent difference, and bits shifted out still take part in rounding as guard and sticky information.
- R3: With `do_sub`=1 the sign of `op_b` is inverted before the operation. An exact cancellation of nonzero values gives +0 (0x00000000).
- R4: A result exactly halfway between two representable values rounds to the one whose last fraction bit is 0.
- R5: A rounding increment that carries out of the significand renormalizes one place and increments the exponent. For example, (2-2^-23) plus 2^-24 gives 2.0 (0x40000000).
- R6: A rounded exponent above 254 gives a signed infinity (exponent field all ones, fraction 0) with `flag_overflow`=1. `flag_overflow` is 0 otherwise.
- R7: A NaN input (exponent field all ones, fraction nonzero) on either side gives the quiet NaN 0x7FC00000 with `flag_invalid`=0.
- R8: Infinities of opposite effective sign (+inf plus -inf, or like-signed infinities subtracted) give 0x7FC00000 with `flag_invalid`=1.
- R9: Otherwise, if an operand is infinite, the result is that infinity with its effective sign. Two infinities of equal effective sign give that infinity.
- R10: An input with exponent field 0 is taken as a zero of its own sign, whatever its fraction.
- R11: When both operands are zero, the result is -0 (0x80000000) only if both effective signs are negative, and +0 otherwise. A nonzero finite value plus a zero returns that value unchanged.
- R12: A finite nonzero result whose normalized exponent falls below 1 is flushed to a zero carrying the result sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and `do_sub` are taken this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| do_sub | input | 1 | 1 selects op_a minus op_b, 0 selects op_a plus op_b |
| out_valid | output | 1 | Result of the previous cycle's inputs is present |
| result | output | 32 | Packed floating-point result |
| flag_invalid | output | 1 | Invalid operation: opposing infinities |
| flag_overflow | output | 1 | Rounded result exceeded the largest finite value |

## Verification
The whole arithmetic path is combinational into a single output register. The result, both flags and `out_valid` are therefore all due exactly one rising edge after the cycle that carries `in_valid`. The bench drives each operand pair on a falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. A back-to-back scenario holds `in_valid` high for consecutive cycles and checks each result in its own cycle. A final check confirms that `out_valid` drops one cycle after the strobe does.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int SIG_W  = MAN_W + 1;        // with hidden one
  localparam int EXT_W  = SIG_W + 3;        // plus guard, round, sticky
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam int EXS_W  = EXP_W + 2;        // signed working exponent

  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    fp_cls_e          cls;
  } fp_unp_t;

  // Right shift that folds every bit pushed out of the word into bit 0.
  function automatic logic [EXT_W-1:0] f_shr_sticky(
    input logic [EXT_W-1:0] v,
    input logic [EXP_W-1:0] amt
  );
    logic [EXT_W-1:0] lost_mask;
    logic [EXT_W-1:0] moved;
    lost_mask = ~({EXT_W{1'b1}} << amt);
    moved     = v >> amt;
    return {moved[EXT_W-1:1], moved[0] | (|(v & lost_mask))};
  endfunction

  // Number of zeros above the highest set bit; EXT_W when v is zero.
  function automatic logic [LZ_W-1:0] f_lzc(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] cnt;
    cnt = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++) begin
      if (v[i]) cnt = LZ_W'(EXT_W - 1 - i);
    end
    return cnt;
  endfunction

  // Round-to-nearest-even increment decision.
  function automatic logic f_rne_inc(
    input logic lsb,
    input logic guard,
    input logic rest
  );
    return guard & (rest | lsb);
  endfunction
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              flip,
  output fp_unp_t           unp
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_zero;
  logic             exp_full;

  assign exp_f    = word[WORD_W-2:MAN_W];
  assign frac_f   = word[MAN_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_full = (exp_f == EXP_ONES);

  always_comb begin
    unp.sgn = word[WORD_W-1] ^ flip;
    if (exp_zero) begin
      // subnormals are flushed: keep only the sign
      unp.exp = '0;
      unp.sig = '0;
      unp.cls = CLS_ZERO;
    end else begin
      unp.exp = exp_f;
      unp.sig = {1'b1, frac_f};
      if (!exp_full)           unp.cls = CLS_NORM;
      else if (frac_f == '0)   unp.cls = CLS_INF;
      else                     unp.cls = CLS_NAN;
    end
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fp_unp_t          opa,
  input  fp_unp_t          opb,
  output logic             big_sgn,
  output logic [EXP_W-1:0] big_exp,
  output logic [EXT_W-1:0] big_ext,
  output logic [EXT_W-1:0] small_ext,
  output logic             eff_sub
);
  logic             swap;
  logic [EXP_W-1:0] small_exp;
  logic [SIG_W-1:0] big_sig;
  logic [SIG_W-1:0] small_sig;
  logic [EXP_W-1:0] exp_diff;

  // magnitude order decides which operand leads
  assign swap = {opb.exp, opb.sig} > {opa.exp, opa.sig};

  always_comb begin
    if (swap) begin
      big_sgn   = opb.sgn;
      big_exp   = opb.exp;
      big_sig   = opb.sig;
      small_exp = opa.exp;
      small_sig = opa.sig;
    end else begin
      big_sgn   = opa.sgn;
      big_exp   = opa.exp;
      big_sig   = opa.sig;
      small_exp = opb.exp;
      small_sig = opb.sig;
    end
  end

  assign eff_sub   = opa.sgn ^ opb.sgn;
  assign exp_diff  = big_exp - small_exp;
  assign big_ext   = {big_sig, 3'b000};
  assign small_ext = f_shr_sticky({small_sig, 3'b000}, exp_diff);

  AST_ALIGN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    big_exp >= small_exp);  // R2
endmodule

// File: rtl/fpa_round.sv
module fpa_round
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eff_sub,
  input  logic              big_sgn,
  input  logic [EXP_W-1:0]  big_exp,
  input  logic [EXT_W-1:0]  big_ext,
  input  logic [EXT_W-1:0]  small_ext,
  output logic [WORD_W-1:0] word,
  output logic              ovf
);
  localparam logic signed [EXS_W-1:0] S_ONE  = EXS_W'(1);
  localparam logic signed [EXS_W-1:0] S_ZERO = '0;
  localparam logic signed [EXS_W-1:0] S_EMAX = $signed({2'b00, EXP_ONES});

  logic [EXT_W:0]            raw_sum;
  logic                      cancel_zero;
  logic                      sum_carry;
  logic [LZ_W-1:0]           lead_zeros;
  logic [EXT_W-1:0]          norm;
  logic signed [EXS_W-1:0]   exp_in;
  logic signed [EXS_W-1:0]   exp_norm;
  logic signed [EXS_W-1:0]   exp_rnd;
  logic                      rnd_inc;
  logic [SIG_W:0]            rnd_sum;
  logic                      rnd_carry;
  logic [MAN_W-1:0]          frac_out;
  logic                      underflow;

  // add/subtract stage
  assign raw_sum = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                           : ({1'b0, big_ext} + {1'b0, small_ext});
  assign cancel_zero = (raw_sum == '0);
  assign sum_carry   = raw_sum[EXT_W];
  assign lead_zeros  = f_lzc(raw_sum[EXT_W-1:0]);
  assign exp_in      = $signed({2'b00, big_exp});

  // normalize stage
  always_comb begin
    if (sum_carry) begin
      norm     = {raw_sum[EXT_W:2], raw_sum[1] | raw_sum[0]};
      exp_norm = exp_in + S_ONE;
    end else begin
      norm     = raw_sum[EXT_W-1:0] << lead_zeros;
      exp_norm = exp_in - $signed({{(EXS_W-LZ_W){1'b0}}, lead_zeros});
    end
  end

  // round stage
  assign rnd_inc   = f_rne_inc(norm[3], norm[2], norm[1] | norm[0]);
  assign rnd_sum   = {1'b0, norm[EXT_W-1:3]} + {{SIG_W{1'b0}}, rnd_inc};
  assign rnd_carry = rnd_sum[SIG_W];
  assign frac_out  = rnd_carry ? rnd_sum[MAN_W:1] : rnd_sum[MAN_W-1:0];
  assign exp_rnd   = rnd_carry ? (exp_norm + S_ONE) : exp_norm;

  assign underflow = !cancel_zero && (exp_norm <= S_ZERO);
  assign ovf       = !cancel_zero && !underflow && (exp_rnd >= S_EMAX);

  // pack stage
  always_comb begin
    if (cancel_zero)    word = '0;
    else if (underflow) word = {big_sgn, {(WORD_W-1){1'b0}}};
    else if (ovf)       word = {big_sgn, EXP_ONES, {MAN_W{1'b0}}};
    else                word = {big_sgn, exp_rnd[EXP_W-1:0], frac_out};
  end

  AST_NORM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cancel_zero |-> norm[EXT_W-1]);  // R2
  AST_CARRY_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    sum_carry |-> !eff_sub);  // R3
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              do_sub,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic              flag_invalid,
  output logic              flag_overflow
);
  localparam int N_OPS = 2;

  fp_unp_t           opu [N_OPS];
  logic              big_sgn;
  logic [EXP_W-1:0]  big_exp;
  logic [EXT_W-1:0]  big_ext;
  logic [EXT_W-1:0]  small_ext;
  logic              eff_sub;
  logic [WORD_W-1:0] dp_word;
  logic              dp_ovf;

  logic              any_nan;
  logic              inf_clash;
  logic [WORD_W-1:0] final_word;
  logic              final_inv;
  logic              final_ovf;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_unp
    fpa_unpack u_unp (
      .word (gi == 0 ? op_a : op_b),
      .flip (gi == 0 ? 1'b0 : do_sub),
      .unp  (opu[gi])
    );
  end

  fpa_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa       (opu[0]),
    .opb       (opu[1]),
    .big_sgn   (big_sgn),
    .big_exp   (big_exp),
    .big_ext   (big_ext),
    .small_ext (small_ext),
    .eff_sub   (eff_sub)
  );

  fpa_round u_round (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_sub   (eff_sub),
    .big_sgn   (big_sgn),
    .big_exp   (big_exp),
    .big_ext   (big_ext),
    .small_ext (small_ext),
    .word      (dp_word),
    .ovf       (dp_ovf)
  );

  // special-operand control and sign logic
  assign any_nan   = (opu[0].cls == CLS_NAN) || (opu[1].cls == CLS_NAN);
  assign inf_clash = (opu[0].cls == CLS_INF) && (opu[1].cls == CLS_INF) &&
                     (opu[0].sgn != opu[1].sgn);

  always_comb begin
    final_inv = 1'b0;
    final_ovf = 1'b0;
    if (any_nan) begin
      final_word = QNAN_WORD;
    end else if (inf_clash) begin
      final_word = QNAN_WORD;
      final_inv  = 1'b1;
    end else if (opu[0].cls == CLS_INF) begin
      final_word = {opu[0].sgn, EXP_ONES, {MAN_W{1'b0}}};
    end else if (opu[1].cls == CLS_INF) begin
      final_word = {opu[1].sgn, EXP_ONES, {MAN_W{1'b0}}};
    end else if ((opu[0].cls == CLS_ZERO) && (opu[1].cls == CLS_ZERO)) begin
      final_word = {opu[0].sgn & opu[1].sgn, {(WORD_W-1){1'b0}}};
    end else begin
      final_word = dp_word;
      final_ovf  = dp_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_overflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= final_word;
        flag_invalid  <= final_inv;
        flag_overflow <= final_ovf;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_overflow) |->
      (result[WORD_W-2:0] == {EXP_ONES, {MAN_W{1'b0}}}));  // R6
  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (result == QNAN_WORD && !flag_overflow));  // R8
  AST_NAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_a[WORD_W-2:MAN_W] == EXP_ONES && op_a[MAN_W-1:0] != '0) |=>
      (result == QNAN_WORD && !flag_invalid));  // R7
endmodule

// File: tb/fp32_addsub_bench.sv
module fp32_addsub_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        do_sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid;
  logic        flag_overflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  fp32_addsub u_fp32_addsub (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .op_a          (op_a),
    .op_b          (op_b),
    .do_sub        (do_sub),
    .out_valid     (out_valid),
    .result        (result),
    .flag_invalid  (flag_invalid),
    .flag_overflow (flag_overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one operation: drive on a falling edge, sample one rising edge later
  task automatic do_op(input string req, input logic [31:0] a,
                       input logic [31:0] b, input logic sub,
                       input logic [31:0] exp_res, input logic exp_inv,
                       input logic exp_ovf);
    @(negedge clk);
    op_a = a; op_b = b; do_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, result, exp_res);
    check(req, {31'd0, flag_invalid}, {31'd0, exp_inv});
    check(req, {31'd0, flag_overflow}, {31'd0, exp_ovf});
  endtask

  task automatic t_reset_state();
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    check("R1 reset flags", {30'd0, flag_invalid, flag_overflow}, 32'd0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000; do_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R1 valid after strobe", {31'd0, out_valid}, 32'd1);
    check("R1 first result", result, 32'h40000000);
    op_a = 32'h3F800000; op_b = 32'h40000000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 back-to-back result", result, 32'h40400000);
    @(negedge clk);
    check("R1 valid drops", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_add_basic();
    do_op("R2 1+2", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 0, 0);
    do_op("R2 1+(-3)", 32'h3F800000, 32'hC0400000, 1'b0, 32'hC0000000, 0, 0);
    do_op("R2 sticky above half", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 0, 0);
    do_op("R2 far shift", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 0, 0);
  endtask

  task automatic t_sub();
    do_op("R3 1.5-0.5", 32'h3FC00000, 32'h3F000000, 1'b1, 32'h3F800000, 0, 0);
    do_op("R3 1-(-1)", 32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 0, 0);
    do_op("R3 1-1 is +0", 32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 0, 0);
    do_op("R3 -1+1 is +0", 32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 0, 0);
  endtask

  task automatic t_ties();
    do_op("R4 tie to even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 0, 0);
    do_op("R4 tie to even up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 0, 0);
  endtask

  task automatic t_round_carry();
    do_op("R5 carry renormalize", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 0, 0);
  endtask

  task automatic t_overflow();
    do_op("R6 positive overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 0, 1);
    do_op("R6 negative overflow", 32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 0, 1);
  endtask

  task automatic t_nan();
    do_op("R7 nan a", 32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 0, 0);
    do_op("R7 nan b signed", 32'h3F800000, 32'hFF812345, 1'b1, 32'h7FC00000, 0, 0);
  endtask

  task automatic t_inf();
    do_op("R8 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1, 0);
    do_op("R8 inf+(-inf)", 32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 1, 0);
    do_op("R9 inf+inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 0, 0);
    do_op("R9 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 0, 0);
    do_op("R9 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 0, 0);
  endtask

  task automatic t_denormal();
    do_op("R10 1+denorm", 32'h3F800000, 32'h00400000, 1'b0, 32'h3F800000, 0, 0);
    do_op("R10 denorm+denorm", 32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 0, 0);
    do_op("R10 neg denorms", 32'h80000001, 32'h80000001, 1'b0, 32'h80000000, 0, 0);
  endtask

  task automatic t_zero();
    do_op("R11 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 0, 0);
    do_op("R11 +0+-0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 0, 0);
    do_op("R11 0-0", 32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 0, 0);
    do_op("R11 -0-0", 32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 0, 0);
    do_op("R11 x+0", 32'h40490FDB, 32'h00000000, 1'b0, 32'h40490FDB, 0, 0);
  endtask

  task automatic t_underflow();
    do_op("R12 tiny positive", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 0, 0);
    do_op("R12 tiny negative", 32'h00800000, 32'h00800001, 1'b1, 32'h80000000, 0, 0);
    do_op("R12 half min normal", 32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_latency();
    t_add_basic();
    t_sub();
    t_ties();
    t_round_carry();
    t_overflow();
    t_nan();
    t_inf();
    t_denormal();
    t_zero();
    t_underflow();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule